// File: doc/BRIEF.md
# Code-Protect-Aware Memory Checksum Engine

This block forms the 16-bit checksum of a program-memory image while the words stream past, together with a configuration word and four identification words. A start strobe opens a frame. At that moment the block captures the configuration word and the identification words. The code-protect bit of the captured configuration word then picks one of two formulas.

With protection off, the sum covers every word addressed from 0x000 to 0x7FE. With protection on, it covers only the words from 0x000 to 0x03F, and it adds a 16-bit value built from the low nibbles of the identification words. In both modes a masked copy of the configuration word is added. Words may arrive in any address order, and any word outside the selected window is dropped.

The frame closes on the word flagged last. The result appears on a registered output together with a one-cycle done pulse. The result then holds until the next frame completes.

Top module: `cks_engine`

## Requirements
- R1: While reset is asserted and after it is released, `csum` reads 0x0000 and `done` reads 0 until a frame completes.
- R2: When bit 4 of the captured configuration word is 1 (protection off), the result is the sum of all accepted words with address 0x000 to 0x7FE, plus the configuration word AND 0x3FF.
- R3: When bit 4 of the captured configuration word is 0 (protection on), the result is the sum of accepted words with address 0x000 to 0x03F, plus the configuration word AND 0x3FF, plus the packed identification value.
- R4: The packed identification value puts bits 3:0 of id0 (`id_words[3:0]`) in result bits 15:12, and so on down to id3 (`id_words[39:36]`) in bits 3:0. For example, identification words 1, 2, 3 and 4 give 0x1234.
- R5: Every addition keeps the low 16 bits only, and carries out of bit 15 are discarded.
- R6: An accepted word whose address lies outside the selected window adds nothing, whatever the arrival order. This includes 0x7FF when protection is off and 0x040 when protection is on. A word flagged last still closes the frame even when its address is outside the window.
- R7: `done` is high for exactly one cycle, in the cycle after the word flagged last is accepted. `csum` changes only in that cycle and holds its value otherwise.
- R8: `start` clears the running sum. A word presented in the same cycle as `start` is dropped, and words presented while no frame is open are ignored.
- R9: The configuration and identification words are sampled only when `start` is high. Changing them during a frame has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a frame and captures configuration and identification words |
| cfg_word | input | 12 | Configuration word; bit 4 is the code-protect bit (0 = protected) |
| id_words | input | 48 | Four 12-bit identification words, id0 in bits 11:0 |
| word_valid | input | 1 | A memory word is presented this cycle |
| word_last | input | 1 | The presented word closes the frame |
| word_addr | input | 12 | Address of the presented word |
| word_data | input | 12 | Memory word, zero-extended to 16 bits |
| csum | output | 16 | Registered checksum of the last completed frame |
| done | output | 1 | One-cycle pulse when `csum` is updated |

## Verification
The assertions assume that `start` is never raised in the same cycle as the last word of a frame. They also assume that a frame always closes before the next `start`, except when a frame is deliberately abandoned and restarted, where the running sum is simply discarded.

The stimulus drives all inputs on the falling clock edge, so captured values are never ambiguous. The bench keeps at least one idle cycle between a closing word and the next `start`. The restart test raises `start` only while the frame is open and no word flagged last is present.

// File: rtl/cks_pkg.sv
package cks_pkg;

    localparam int SUM_W = 16;

    typedef struct packed {
        logic             busy;
        logic             prot;
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] base;
        logic [SUM_W-1:0] csum;
        logic             done;
    } cks_state_t;

endpackage

// File: rtl/cks_id_pack.sv
module cks_id_pack #(
    parameter int N_ID  = 4,
    parameter int ID_W  = 12,
    parameter int NIB_W = 4,
    parameter int OUT_W = 16
) (
    input  logic [N_ID*ID_W-1:0] id_words,
    output logic [OUT_W-1:0]     packed_id
);
    localparam int USED_W = N_ID * NIB_W;

    logic [USED_W-1:0] nibbles;

    // id0 lands in the most significant nibble
    for (genvar i = 0; i < N_ID; i++) begin : g_nib
        assign nibbles[USED_W-1-i*NIB_W -: NIB_W] = id_words[i*ID_W +: NIB_W];
    end

    if (USED_W >= OUT_W) begin : g_trunc
        assign packed_id = nibbles[OUT_W-1:0];
    end else begin : g_ext
        assign packed_id = {{(OUT_W-USED_W){1'b0}}, nibbles};
    end
endmodule

// File: rtl/cks_base_term.sv
module cks_base_term #(
    parameter int          CFG_W    = 12,
    parameter int          N_ID     = 4,
    parameter int          NIB_W    = 4,
    parameter int          SUM_W    = 16,
    parameter int          CP_BIT   = 4,
    parameter logic [11:0] CFG_MASK = 12'h3FF
) (
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [N_ID*CFG_W-1:0] id_words,
    output logic                  prot,
    output logic [SUM_W-1:0]      base
);
    logic [SUM_W-1:0] packed_id;
    logic [CFG_W-1:0] cfg_masked;

    cks_id_pack #(
        .N_ID (N_ID),
        .ID_W (CFG_W),
        .NIB_W(NIB_W),
        .OUT_W(SUM_W)
    ) u_pack (
        .id_words (id_words),
        .packed_id(packed_id)
    );

    always_comb begin
        prot       = ~cfg_word[CP_BIT];
        cfg_masked = cfg_word & CFG_MASK[CFG_W-1:0];
        base       = {{(SUM_W-CFG_W){1'b0}}, cfg_masked};
        if (prot) begin
            base = base + packed_id;
        end
    end
endmodule

// File: rtl/cks_window.sv
module cks_window #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 12,
    parameter int SUM_W     = 16,
    parameter int PROT_LAST = 'h03F,
    parameter int OPEN_LAST = 'h7FE
) (
    input  logic              prot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              in_range,
    output logic [SUM_W-1:0]  term
);
    localparam logic [ADDR_W-1:0] PROT_LIM = PROT_LAST[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OPEN_LIM = OPEN_LAST[ADDR_W-1:0];

    always_comb begin
        in_range = prot ? (addr <= PROT_LIM) : (addr <= OPEN_LIM);
        term     = in_range ? {{(SUM_W-DATA_W){1'b0}}, data} : '0;
    end
endmodule

// File: rtl/cks_engine.sv
module cks_engine
    import cks_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 12,
    parameter int          CFG_W     = 12,
    parameter int          N_ID      = 4,
    parameter int          NIB_W     = 4,
    parameter int          CP_BIT    = 4,
    parameter int          PROT_LAST = 'h03F,
    parameter int          OPEN_LAST = 'h7FE,
    parameter logic [11:0] CFG_MASK  = 12'h3FF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [N_ID*CFG_W-1:0] id_words,
    input  logic                  word_valid,
    input  logic                  word_last,
    input  logic [ADDR_W-1:0]     word_addr,
    input  logic [DATA_W-1:0]     word_data,
    output logic [SUM_W-1:0]      csum,
    output logic                  done
);
    localparam logic [ADDR_W-1:0] PROT_LIM = PROT_LAST[ADDR_W-1:0];

    cks_state_t st_d, st_q;

    logic             prot_w;
    logic [SUM_W-1:0] base_w;
    logic             in_range_w;
    logic [SUM_W-1:0] term_w;
    logic [SUM_W-1:0] acc_next;
    logic             accept;

    cks_base_term #(
        .CFG_W   (CFG_W),
        .N_ID    (N_ID),
        .NIB_W   (NIB_W),
        .SUM_W   (SUM_W),
        .CP_BIT  (CP_BIT),
        .CFG_MASK(CFG_MASK)
    ) u_base (
        .cfg_word(cfg_word),
        .id_words(id_words),
        .prot    (prot_w),
        .base    (base_w)
    );

    cks_window #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SUM_W    (SUM_W),
        .PROT_LAST(PROT_LAST),
        .OPEN_LAST(OPEN_LAST)
    ) u_win (
        .prot    (st_q.prot),
        .addr    (word_addr),
        .data    (word_data),
        .in_range(in_range_w),
        .term    (term_w)
    );

    assign accept   = word_valid && st_q.busy && !start;
    assign acc_next = st_q.acc + term_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.acc  = '0;
            st_d.prot = prot_w;
            st_d.base = base_w;
        end else if (accept) begin
            st_d.acc = acc_next;
            if (word_last) begin
                st_d.busy = 1'b0;
                st_d.csum = acc_next + st_q.base;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csum = st_q.csum;
    assign done = st_q.done;

    // done only ever follows an accepted closing word
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_valid && word_last && st_q.busy && !start));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_csum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(csum));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> $stable(st_q.acc));

    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && st_q.acc == '0));

    p_prot_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.prot && word_valid && !start && word_addr > PROT_LIM)
        |=> $stable(st_q.acc));

    p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !start) |=> $stable(st_q.prot) && $stable(st_q.base));
endmodule

// File: tb/cks_engine_test.sv
module cks_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_word = '0;
    logic [47:0] id_words = '0;
    logic        word_valid = 1'b0;
    logic        word_last = 1'b0;
    logic [11:0] word_addr = '0;
    logic [11:0] word_data = '0;
    logic [15:0] csum;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    localparam logic [11:0] V_CFG [NVEC] = '{12'hFFF, 12'hFEF, 12'h5A5, 12'h0B1, 12'h010, 12'h000};
    localparam logic [47:0] V_IDS [NVEC] = '{48'h0, 48'h004003002001, 48'hABCDEF123456,
                                             48'h111222333444, 48'h0, 48'hFFFFFFFFFFFF};
    localparam int V_N  [NVEC] = '{40, 100, 80, 60, 30, 1};
    localparam int V_A0 [NVEC] = '{'h000, 'h000, 'h07F, 'h7E0, 'h100, 'h03F};
    localparam int V_AS [NVEC] = '{1, 1, 'hFFF, 1, 'h40, 1};
    localparam int V_D0 [NVEC] = '{'h123, 'hFFF, 'h800, 'hFFF, 'h3C5, 'hABC};
    localparam int V_DS [NVEC] = '{'h007, 0, 'h011, 'hFFF, 'h101, 0};
    localparam string V_TAG [NVEC] = '{"R2", "R3", "R3", "R6", "R2", "R3"};

    cks_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_word  (cfg_word),
        .id_words  (id_words),
        .word_valid(word_valid),
        .word_last (word_last),
        .word_addr (word_addr),
        .word_data (word_data),
        .csum      (csum),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [11:0] cfg, input logic [47:0] ids,
                                          input logic [15:0] wsum);
        logic [15:0] r;
        r = wsum + {4'h0, cfg & 12'h3FF};
        if (!cfg[4]) r = r + {ids[3:0], ids[15:12], ids[27:24], ids[39:36]};
        return r;
    endfunction

    function automatic logic in_win(input logic [11:0] cfg, input logic [11:0] a);
        return cfg[4] ? (a <= 12'h7FE) : (a <= 12'h03F);
    endfunction

    task automatic open_frame(input logic [11:0] cfg, input logic [47:0] ids);
        cfg_word = cfg;
        id_words = ids;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic put_word(input logic [11:0] a, input logic [11:0] d, input logic last);
        word_valid = 1'b1;
        word_addr  = a;
        word_data  = d;
        word_last  = last;
        @(negedge clk);
        word_valid = 1'b0;
        word_last  = 1'b0;
    endtask

    // streams n words, returns expected result; done/csum are checked by caller
    task automatic stream(input logic [11:0] cfg, input logic [47:0] ids, input int n,
                          input int a0, input int as, input int d0, input int ds,
                          output logic [15:0] exp);
        logic [15:0] wsum = '0;
        open_frame(cfg, ids);
        for (int k = 0; k < n; k++) begin
            logic [11:0] a, d;
            a = 12'(a0 + k * as);
            d = 12'(d0 + k * ds);
            if (in_win(cfg, a)) wsum = wsum + {4'h0, d};
            put_word(a, d, k == n - 1);
        end
        exp = model(cfg, ids, wsum);
    endtask

    task automatic expect_done(input string tag, input logic [15:0] exp);
        logic [15:0] held;
        check(done === 1'b1, {tag, " R7 done pulse"}, {15'h0, done}, 16'h1);
        check(csum === exp, {tag, " result"}, csum, exp);
        held = csum;
        @(negedge clk);
        check(done === 1'b0, {tag, " R7 pulse width"}, {15'h0, done}, 16'h0);
        check(csum === held, {tag, " R7 hold"}, csum, held);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R7 actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp;
        logic [15:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(csum === 16'h0 && done === 1'b0, "R1 during reset", csum, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(csum === 16'h0 && done === 1'b0, "R1 after reset", csum, 16'h0);

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            stream(V_CFG[v], V_IDS[v], V_N[v], V_A0[v], V_AS[v], V_D0[v], V_DS[v], exp);
            expect_done(V_TAG[v], exp);
        end

        // R4: packing example 1,2,3,4 with no words in window and cfg low bits clear
        open_frame(12'h000, 48'h004003002001);
        put_word(12'h800, 12'hFFF, 1'b1);
        expect_done("R4 packing", 16'h1234);

        // R5: blank image, protection off, wraps to 0xEC00
        stream(12'hFFF, 48'h0, 2048, 0, 1, 'hFFF, 0, exp);
        check(exp === 16'hEC00, "R5 model", exp, 16'hEC00);
        expect_done("R5 blank open", 16'hEC00);

        // R3/R5: blank image, protection on, wraps to 0x03AE
        stream(12'hFEF, 48'hFFFFFFFFFFFF, 2048, 'h7FF, 'hFFF, 'hFFF, 0, exp);
        expect_done("R3 blank protected", 16'h03AE);

        // R8: words while idle are ignored
        held = csum;
        put_word(12'h000, 12'h111, 1'b1);
        put_word(12'h001, 12'h222, 1'b1);
        check(done === 1'b0 && csum === held, "R8 idle words", csum, held);

        // R8: start drops a same-cycle word
        cfg_word   = 12'h010;
        id_words   = '0;
        start      = 1'b1;
        word_valid = 1'b1;
        word_addr  = 12'h000;
        word_data  = 12'h555;
        @(negedge clk);
        start      = 1'b0;
        word_valid = 1'b0;
        put_word(12'h001, 12'h001, 1'b1);
        expect_done("R8 start priority", 16'h0011);

        // R8: restart mid-frame discards running sum
        open_frame(12'h010, '0);
        put_word(12'h002, 12'h700, 1'b0);
        put_word(12'h003, 12'h070, 1'b0);
        open_frame(12'h010, '0);
        put_word(12'h004, 12'h002, 1'b1);
        expect_done("R8 restart", 16'h0012);

        // R9: configuration and IDs changed mid-frame have no effect
        open_frame(12'hFFF, 48'h0);
        cfg_word = 12'h000;
        id_words = 48'hFFFFFFFFFFFF;
        put_word(12'h100, 12'h010, 1'b0);
        put_word(12'h7FF, 12'h999, 1'b0);
        put_word(12'h020, 12'h001, 1'b1);
        expect_done("R9 capture", 16'h0410);

        // R6: protected window boundary 0x03F in, 0x040 out
        open_frame(12'h000, 48'h0);
        put_word(12'h040, 12'h800, 1'b0);
        put_word(12'h03F, 12'h00A, 1'b1);
        expect_done("R6 protected edge", 16'h000A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule